// File: doc/BRIEF.md
# Serial Flash Status Auto-Poller

This block keeps reading a serial flash status register until its contents reach a wanted state. A start strobe launches a loop. Each pass asks a serial read engine for a status read of 1 to 4 bytes and packs the returned bytes into one word. A mask picks the bits that take part, and those bits are compared with a match value. Two comparison rules are available: every selected bit must agree, or any one selected bit that agrees is enough.

A programmable gap separates one read from the next. On a hit a sticky match flag is set. The loop then either stops by itself or keeps polling until an abort. The configuration is captured when the loop starts, so the inputs may change while the loop runs.

The read engine sees a level request and a byte count. It answers with one valid-qualified byte per cycle, least significant byte first. The wire protocol belongs to that engine and is not part of this block.

Top module: `flash_stat_poller`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o` and `match_flag_o` are 0 and `status_o` is 0.
- R2: When `start_i` is high while idle, `busy_o` and `rd_req_o` are high from the next cycle. `busy_o` stays high until the loop ends. `rd_len_o` carries the captured byte count.
- R3: Byte count encoding: `cfg_len_i` = N-1 requests N bytes. Byte k of a read lands at bits [8k+7:8k] of `status_o`. Bytes above N-1 read as zero. `status_o` holds the last completed read.
- R4: With `cfg_or_mode_i`=0, a read is a hit only when every bit with mask 1 equals the same bit of the match value.
- R5: With `cfg_or_mode_i`=1, a read is a hit when at least one bit with mask 1 equals the same bit of the match value.
- R6: With an all-zero mask, the first rule always gives a hit and the second rule never does.
- R7: Between the last byte of one read and the next request, `rd_req_o` is low for exactly `cfg_gap_i`+1 cycles. A gap of 0 gives a single low cycle.
- R8: With `cfg_auto_stop_i`=1, a hit ends the loop: `busy_o` falls in the cycle the flag rises.
- R9: With `cfg_auto_stop_i`=0, a hit sets the flag, but `busy_o` stays high and reads go on.
- R10: An abort during a read takes effect only after that read's last byte. The loop then goes idle without judging that read. An abort while judging or waiting ends the loop on the next clock edge without setting the flag.
- R11: `match_flag_o` rises one cycle after the last byte of a hit read. It stays set until `flag_clr_i` is pulsed, whether polling goes on or the loop ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a polling loop when idle |
| abort_i | input | 1 | Ends the polling loop |
| cfg_mask_i | input | 32 | Bits that take part in the comparison |
| cfg_match_i | input | 32 | Wanted value of the selected bits |
| cfg_gap_i | input | 16 | Extra idle cycles between reads |
| cfg_len_i | input | 2 | Status length in bytes, minus one |
| cfg_or_mode_i | input | 1 | 0: all selected bits agree; 1: any selected bit agrees |
| cfg_auto_stop_i | input | 1 | Stop on the first hit |
| rd_req_o | output | 1 | Status read request to the read engine |
| rd_len_o | output | 2 | Byte count of the requested read, minus one |
| rd_vld_i | input | 1 | Byte from the read engine is valid |
| rd_byte_i | input | 8 | Returned status byte |
| match_flag_o | output | 1 | Sticky hit flag |
| flag_clr_i | input | 1 | Clears the hit flag |
| busy_o | output | 1 | Polling loop active |
| status_o | output | 32 | Last assembled status word |

## Verification
A vector table runs single reads through both comparison rules. In the table, selected bits that all agree, all disagree, or only partly agree separate the two rules from each other. An all-zero mask shows which rule reports a constant result. Masks placed on the upper bytes of 2-, 3- and 4-byte reads catch a swapped byte order and upper bytes that are not zeroed. Directed tests measure the gap at 0 and at 5 cycles, keep polling across two hits, and abort in the middle of a read carrying a matching value, which tells deferred abort apart from an early judgement.

// File: rtl/stpoll_pkg.sv
package stpoll_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_EVAL = 2'd2,
      ST_WAIT = 2'd3
   } poll_state_e;

endpackage

// File: rtl/stpoll_assemble.sv
module stpoll_assemble #(
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8,
   localparam int WORD_W = BYTES * BYTE_W,
   localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              vld_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [WORD_W-1:0] word_o
);

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   lane_q <= '0;
         else if (clr_i)                               lane_q <= '0;
         else if (vld_i && (idx_i == IDX_W'(g)))       lane_q <= byte_i;
      end
      assign word_o[g*BYTE_W +: BYTE_W] = lane_q;
   end

   // R3: a new read starts from an all-zero word
   p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> word_o == '0);

   // R3: an accepted byte appears in the lane chosen by its index
   p_lane_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !clr_i) |=> word_o[$past(idx_i)*BYTE_W +: BYTE_W] == $past(byte_i));

endmodule

// File: rtl/stpoll_compare.sv
module stpoll_compare #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [WORD_W-1:0] mask_i,
   input  logic [WORD_W-1:0] match_i,
   input  logic              or_mode_i,
   output logic              hit_o
);

   logic [WORD_W-1:0] agree;

   always_comb begin
      agree = ~(word_i ^ match_i) & mask_i;
      if (or_mode_i) hit_o = |agree;
      else           hit_o = (agree == mask_i);
   end

endmodule

// File: rtl/stpoll_gap_timer.sv
module stpoll_gap_timer #(
   parameter int GAP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [GAP_W-1:0] gap_i,
   output logic             last_o
);

   logic [GAP_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= gap_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign last_o = (cnt_q == GAP_W'(1));

   // R7: a running count drops by exactly one each cycle
   p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/flash_stat_poller.sv
module flash_stat_poller
   import stpoll_pkg::*;
#(
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8,
   parameter int GAP_W  = 16,
   localparam int WORD_W = BYTES * BYTE_W,
   localparam int LEN_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic [WORD_W-1:0] cfg_mask_i,
   input  logic [WORD_W-1:0] cfg_match_i,
   input  logic [GAP_W-1:0]  cfg_gap_i,
   input  logic [LEN_W-1:0]  cfg_len_i,
   input  logic              cfg_or_mode_i,
   input  logic              cfg_auto_stop_i,
   output logic              rd_req_o,
   output logic [LEN_W-1:0]  rd_len_o,
   input  logic              rd_vld_i,
   input  logic [BYTE_W-1:0] rd_byte_i,
   output logic              match_flag_o,
   input  logic              flag_clr_i,
   output logic              busy_o,
   output logic [WORD_W-1:0] status_o
);

   if (BYTES < 1 || BYTES > 8) begin : g_bad_bytes
      $error("flash_stat_poller: BYTES must lie in 1..8");
   end
   if (BYTE_W < 1) begin : g_bad_byte_w
      $error("flash_stat_poller: BYTE_W must be positive");
   end
   if (GAP_W < 1 || GAP_W > 32) begin : g_bad_gap_w
      $error("flash_stat_poller: GAP_W must lie in 1..32");
   end

   poll_state_e       state_q, state_d;
   logic [WORD_W-1:0] mask_q, match_q;
   logic [GAP_W-1:0]  gap_q;
   logic [LEN_W-1:0]  len_q;
   logic              or_q, stop_q;
   logic [LEN_W-1:0]  idx_q;
   logic              abort_pend_q;
   logic              flag_q;
   logic              hit;
   logic              tmr_last;
   logic              last_byte;
   logic              launch;
   logic              tmr_load;
   logic              flag_set;

   assign last_byte = (state_q == ST_READ) && rd_vld_i && (idx_q == len_q);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i) state_d = ST_READ;
         ST_READ: if (last_byte) state_d = (abort_pend_q || abort_i) ? ST_IDLE : ST_EVAL;
         ST_EVAL: begin
            if (abort_i)              state_d = ST_IDLE;
            else if (hit && stop_q)   state_d = ST_IDLE;
            else if (gap_q == '0)     state_d = ST_READ;
            else                      state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (abort_i)       state_d = ST_IDLE;
            else if (tmr_last) state_d = ST_READ;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign launch   = (state_d == ST_READ) && (state_q != ST_READ);
   assign tmr_load = (state_q == ST_EVAL) && (state_d == ST_WAIT);
   assign flag_set = (state_q == ST_EVAL) && hit && !abort_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         mask_q       <= '0;
         match_q      <= '0;
         gap_q        <= '0;
         len_q        <= '0;
         or_q         <= 1'b0;
         stop_q       <= 1'b0;
         idx_q        <= '0;
         abort_pend_q <= 1'b0;
         flag_q       <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) begin
            mask_q  <= cfg_mask_i;
            match_q <= cfg_match_i;
            gap_q   <= cfg_gap_i;
            len_q   <= cfg_len_i;
            or_q    <= cfg_or_mode_i;
            stop_q  <= cfg_auto_stop_i;
         end
         if (launch)                               idx_q <= '0;
         else if (state_q == ST_READ && rd_vld_i)  idx_q <= idx_q + 1'b1;
         if (state_q != ST_READ)                   abort_pend_q <= 1'b0;
         else if (abort_i)                         abort_pend_q <= 1'b1;
         if (flag_set)                             flag_q <= 1'b1;
         else if (flag_clr_i)                      flag_q <= 1'b0;
      end
   end

   stpoll_assemble #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_asm (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (launch),
      .vld_i  (rd_vld_i && (state_q == ST_READ)),
      .idx_i  (idx_q),
      .byte_i (rd_byte_i),
      .word_o (status_o)
   );

   stpoll_compare #(.WORD_W(WORD_W)) u_cmp (
      .word_i    (status_o),
      .mask_i    (mask_q),
      .match_i   (match_q),
      .or_mode_i (or_q),
      .hit_o     (hit)
   );

   stpoll_gap_timer #(.GAP_W(GAP_W)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .gap_i  (gap_q),
      .last_o (tmr_last)
   );

   assign rd_req_o     = (state_q == ST_READ);
   assign rd_len_o     = len_q;
   assign busy_o       = (state_q != ST_IDLE);
   assign match_flag_o = flag_q;

   // R2: a start while idle makes the block busy and requesting
   p_start_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && rd_req_o));

   // R4: a hit under the all-agree rule has no disagreeing selected bit
   p_and_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EVAL && !or_q && hit) |-> (((status_o ^ match_q) & mask_q) == '0));

   // R8: a hit with auto-stop ends the loop
   p_auto_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EVAL && hit && stop_q) |=> !busy_o);

   // R10: an abort while judging or waiting ends the loop next cycle
   p_abort_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_EVAL || state_q == ST_WAIT) && abort_i) |=> !busy_o);

   // R10: an aborted read is never judged
   p_no_eval_after_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && (abort_pend_q || abort_i)) |=> !busy_o);

   // R11: the flag only rises after a hit
   p_flag_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(hit && state_q == ST_EVAL));

   // R11: the flag holds without a clear request
   p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr_i) |=> flag_q);

endmodule

// File: tb/flash_stat_poller_tb.sv
module flash_stat_poller_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, abort_i = 1'b0;
   logic [31:0] cfg_mask_i = '0, cfg_match_i = '0;
   logic [15:0] cfg_gap_i = '0;
   logic [1:0]  cfg_len_i = '0;
   logic        cfg_or_mode_i = 1'b0, cfg_auto_stop_i = 1'b1;
   logic        rd_req_o;
   logic [1:0]  rd_len_o;
   logic        rd_vld_i = 1'b0;
   logic [7:0]  rd_byte_i = '0;
   logic        match_flag_o;
   logic        flag_clr_i = 1'b0;
   logic        busy_o;
   logic [31:0] status_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   flash_stat_poller u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .cfg_mask_i(cfg_mask_i), .cfg_match_i(cfg_match_i), .cfg_gap_i(cfg_gap_i),
      .cfg_len_i(cfg_len_i), .cfg_or_mode_i(cfg_or_mode_i),
      .cfg_auto_stop_i(cfg_auto_stop_i), .rd_req_o(rd_req_o), .rd_len_o(rd_len_o),
      .rd_vld_i(rd_vld_i), .rd_byte_i(rd_byte_i), .match_flag_o(match_flag_o),
      .flag_clr_i(flag_clr_i), .busy_o(busy_o), .status_o(status_o)
   );

   localparam int NV = 13;
   localparam logic [31:0] V_MASK  [NV] = '{32'h01, 32'h01, 32'hFF, 32'hFF00, 32'hFF00,
      32'h0F, 32'h0F, 32'h0F, 32'h0, 32'h0, 32'hFF00_0000, 32'hFF00_0000, 32'hFFFF_FFFF};
   localparam logic [31:0] V_MATCH [NV] = '{32'h00, 32'h00, 32'h42, 32'h1200, 32'h3400,
      32'h0A, 32'h0A, 32'h0A, 32'h0, 32'h0, 32'hAB00_0000, 32'h0, 32'h89AB_CDEF};
   localparam logic [31:0] V_RAW   [NV] = '{32'hFFFF_FF00, 32'h01, 32'h42, 32'h1234, 32'h1234,
      32'h05, 32'h0B, 32'h0B, 32'hFF, 32'hFF, 32'hAB00_0000, 32'hAB00_0000, 32'h89AB_CDEF};
   localparam logic [1:0]  V_LEN   [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1,
      2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd2, 2'd3};
   localparam logic        V_OR    [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
      1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
   localparam logic        V_HIT   [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
      1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic begin_poll(input logic [31:0] m, input logic [31:0] v, input logic [15:0] g,
                             input logic [1:0] len, input logic orm, input logic stp);
      cfg_mask_i = m; cfg_match_i = v; cfg_gap_i = g; cfg_len_i = len;
      cfg_or_mode_i = orm; cfg_auto_stop_i = stp;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic serve(input logic [31:0] raw, input int nb);
      for (int i = 0; i < nb; i++) begin
         rd_vld_i = 1'b1;
         rd_byte_i = raw[8*i +: 8];
         @(negedge clk);
      end
      rd_vld_i = 1'b0;
   endtask

   task automatic pulse_abort();
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
   endtask

   task automatic pulse_clear();
      flag_clr_i = 1'b1;
      @(negedge clk);
      flag_clr_i = 1'b0;
   endtask

   task automatic wait_req();
      for (int k = 0; k < 200 && !rd_req_o; k++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 100000", cyc);
         finish_run();
      end
   end

   initial begin
      int cnt;
      logic [31:0] expw;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 busy", {31'b0, busy_o}, 0);
      check("R1 req", {31'b0, rd_req_o}, 0);
      check("R1 flag", {31'b0, match_flag_o}, 0);
      check("R1 status", status_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table
      for (int v = 0; v < NV; v++) begin
         begin_poll(V_MASK[v], V_MATCH[v], 16'd10, V_LEN[v], V_OR[v], 1'b1);
         check("R2 busy after start", {31'b0, busy_o}, 1);
         check("R2 req after start", {31'b0, rd_req_o}, 1);
         check("R2 len", {30'b0, rd_len_o}, {30'b0, V_LEN[v]});
         serve(V_RAW[v], int'(V_LEN[v]) + 1);
         @(negedge clk);
         expw = '0;
         for (int b = 0; b <= int'(V_LEN[v]); b++) expw[8*b +: 8] = V_RAW[v][8*b +: 8];
         check("R3 assembled word", status_o, expw);
         check("R4/R5/R6 flag", {31'b0, match_flag_o}, {31'b0, V_HIT[v]});
         check("R8 busy after judgement", {31'b0, busy_o}, {31'b0, !V_HIT[v]});
         if (busy_o) begin
            pulse_abort();
            check("R10 abort in wait", {31'b0, busy_o}, 0);
         end
         pulse_clear();
         check("R11 clear", {31'b0, match_flag_o}, 0);
      end

      // R7: gap of 5 and of 0
      for (int t = 0; t < 2; t++) begin
         logic [15:0] g;
         g = (t == 0) ? 16'd5 : 16'd0;
         begin_poll(32'h01, 32'h00, g, 2'd0, 1'b0, 1'b1);
         serve(32'h01, 1);
         cnt = 0;
         while (!rd_req_o && cnt < 100) begin
            cnt++;
            @(negedge clk);
         end
         check("R7 low cycles between reads", cnt, int'(g) + 1);
         abort_i = 1'b1;
         rd_vld_i = 1'b1;
         rd_byte_i = 8'h01;
         @(negedge clk);
         abort_i = 1'b0;
         rd_vld_i = 1'b0;
         check("R10 abort on last byte", {31'b0, busy_o}, 0);
      end

      // R10: abort in the middle of a matching read
      begin_poll(32'hFF, 32'h5A, 16'd3, 2'd1, 1'b0, 1'b1);
      serve(32'h5A, 1);
      pulse_abort();
      check("R10 busy held until read ends", {31'b0, busy_o}, 1);
      serve(32'h00, 1);
      check("R10 idle after aborted read", {31'b0, busy_o}, 0);
      check("R10 aborted read not judged", {31'b0, match_flag_o}, 0);

      // R9: keep polling past a hit
      begin_poll(32'h80, 32'h80, 16'd2, 2'd0, 1'b0, 1'b0);
      serve(32'h80, 1);
      @(negedge clk);
      check("R9 flag after first hit", {31'b0, match_flag_o}, 1);
      check("R9 busy after first hit", {31'b0, busy_o}, 1);
      wait_req();
      check("R9 next read requested", {31'b0, rd_req_o}, 1);
      pulse_clear();
      check("R11 clear while polling", {31'b0, match_flag_o}, 0);
      serve(32'h80, 1);
      @(negedge clk);
      check("R9 flag after second hit", {31'b0, match_flag_o}, 1);
      check("R9 busy after second hit", {31'b0, busy_o}, 1);
      pulse_abort();
      check("R10 abort ends continuous loop", {31'b0, busy_o}, 0);
      repeat (5) @(negedge clk);
      check("R11 flag sticky after loop", {31'b0, match_flag_o}, 1);
      pulse_clear();
      check("R11 flag cleared", {31'b0, match_flag_o}, 0);

      finish_run();
   end

endmodule